// File: doc/BRIEF.md
# Modulo Post-Modify Address Generator

This block keeps a bank of address registers for a load/store unit and produces the memory address for each access. It applies the update that the addressing mode asks for: post-increment, post-decrement or pre-decrement. The step is two bytes for a single-word access and four bytes for a double-word access. When circular-buffer mode is on, a post-modified register that sits on the programmed end address is reloaded with the programmed start address instead of being stepped. This lets loops walk a ring buffer without extra instructions.

The access address, the address of the second half of a double-word access, the register's new value and an illegal-use flag are combinational from the current inputs and the bank contents. The new value is written into the bank on the clock edge when the operation enable is high. A load port lets the register file's writeback seed any address register. A read port shows the contents of any register.

Top module: `mod_addr_gen`

## Requirements
- R1: After reset every address register reads back as 0 on the read port.
- R2: Mode code 01 (post-increment) and mode code 10 (post-decrement) drive the access address with the register value before the update, and the new value is the register plus or minus the step. The step is 2 when the size bit is 0 and 4 when the size bit is 1.
- R3: In mode 01 or 10, with the circular bit set and the register equal to the end address, the new value is the start address. With the circular bit clear, or with the register not equal to the end address, the register steps as in R2.
- R4: Mode code 11 (pre-decrement) on register 15 subtracts the step first and uses the result both as access address and as new value, with no circular reload even when the register equals the end address.
- R5: Mode code 11 on any register other than 15 raises the illegal flag, keeps the new value equal to the current value, and leaves the register unchanged after an enabled operation.
- R6: The second-half address output always equals the access address plus 2.
- R7: All address arithmetic is 16 bits wide and wraps modulo 65536.
- R8: Mode code 00 (plain indirect) gives the register value as the access address and as the new value, and does not change the register.
- R9: The register selected by the operation index takes its new value at a clock edge only when the operation enable is high. With the enable low, it is not modified.
- R10: A load with the load enable high writes the load value into the selected register at the clock edge. It wins over an operation commit to the same register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_en | input | 1 | Commit the new value of the selected register at the clock edge |
| op_idx | input | 4 | Address register used by the access |
| op_mode | input | 2 | 00 indirect, 01 post-increment, 10 post-decrement, 11 pre-decrement |
| op_dbl | input | 1 | 0 single-word step (2), 1 double-word step (4) |
| circ_en | input | 1 | Circular-buffer mode enable |
| circ_start | input | 16 | Reload value used on a circular wrap |
| circ_end | input | 16 | Register value that triggers a circular wrap |
| ld_en | input | 1 | Load enable for register seeding |
| ld_idx | input | 4 | Register written by the load |
| ld_val | input | 16 | Value written by the load |
| rd_idx | input | 4 | Register shown on rd_val |
| rd_val | output | 16 | Contents of the register chosen by rd_idx |
| eff_addr | output | 16 | Access address (first half) |
| eff_addr_hi | output | 16 | Second-half address, eff_addr + 2 |
| upd_val | output | 16 | New value for the selected register |
| illegal | output | 1 | Pre-decrement requested on a register other than 15 |

## Verification
The bench seeds a register, then applies each addressing mode at both access sizes. It tells post-modify apart from pre-decrement by which value appears as the access address. It tries the circular bit with the register exactly on the end address, one step short of it, and on it with the circular bit clear, which shows that only an exact match reloads the start value. Decrementing wraps, together with seeds at 0x0000 and 0xFFFE, separate a correct 16-bit modular result from a widened or saturated one. Pre-decrement on register 15 and on another register, with the register sitting on the end address, shows the stack-only rule and the absence of circular reload. Directed cases cover a disabled operation and a load that collides with an operation commit.

// File: rtl/agen_pkg.sv
package agen_pkg;

    typedef enum logic [1:0] {
        AM_HOLD     = 2'b00,
        AM_POST_INC = 2'b01,
        AM_POST_DEC = 2'b10,
        AM_PRE_DEC  = 2'b11
    } am_mode_e;

    // Result of one address computation
    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] upd;
        logic        wr;
        logic        bad;
    } am_res_t;

endpackage

// File: rtl/agen_step.sv
module agen_step #(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic [1:0]    mode,
    input  logic          dbl,
    output logic [AW-1:0] delta
);
    import agen_pkg::*;

    localparam logic [AW-1:0] MAG_W = AW'(WORD_BYTES);
    localparam logic [AW-1:0] MAG_D = AW'(2 * WORD_BYTES);

    logic [AW-1:0] mag;
    logic          down;

    always_comb begin
        mag  = dbl ? MAG_D : MAG_W;
        down = (mode == AM_POST_DEC) || (mode == AM_PRE_DEC);
        if (mode == AM_HOLD) begin
            delta = '0;
        end else if (down) begin
            delta = (~mag) + AW'(1);
        end else begin
            delta = mag;
        end
    end

endmodule

// File: rtl/agen_modify.sv
module agen_modify #(
    parameter int AW     = 16,
    parameter int IW     = 4,
    parameter int SP_IDX = 15
) (
    input  logic [1:0]    mode,
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] delta,
    input  logic          circ,
    input  logic [AW-1:0] start_a,
    input  logic [AW-1:0] end_a,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] upd,
    output logic          wr,
    output logic          bad
);
    import agen_pkg::*;

    logic [AW-1:0] stepped;
    logic          is_post;
    logic          is_pre;
    logic          on_sp;
    logic          wrap_hit;

    always_comb begin
        stepped  = cur + delta;
        is_post  = (mode == AM_POST_INC) || (mode == AM_POST_DEC);
        is_pre   = (mode == AM_PRE_DEC);
        on_sp    = (idx == IW'(SP_IDX));
        wrap_hit = is_post && circ && (cur == end_a);

        addr = cur;
        upd  = cur;
        wr   = 1'b0;
        bad  = 1'b0;

        if (is_post) begin
            wr  = 1'b1;
            upd = wrap_hit ? start_a : stepped;
        end else if (is_pre) begin
            if (on_sp) begin
                wr   = 1'b1;
                addr = stepped;
                upd  = stepped;
            end else begin
                bad = 1'b1;
            end
        end
    end

endmodule

// File: rtl/agen_bank.sv
module agen_bank #(
    parameter int AW   = 16,
    parameter int NREG = 16,
    parameter int IW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_val,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [AW-1:0] ld_val,
    input  logic [IW-1:0] op_idx,
    output logic [AW-1:0] op_val,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_val
);

    typedef struct packed {
        logic [NREG-1:0][AW-1:0] regs;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d.regs[wr_idx] = wr_val;
        end
        // load overrides an operation commit on the same register
        if (ld_en) begin
            bank_d.regs[ld_idx] = ld_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign op_val = bank_q.regs[op_idx];
    assign rd_val = bank_q.regs[rd_idx];

endmodule

// File: rtl/mod_addr_gen.sv
module mod_addr_gen #(
    parameter int AW         = 16,
    parameter int NREG       = 16,
    parameter int SP_IDX     = 15,
    parameter int WORD_BYTES = 2,
    localparam int IW        = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_en,
    input  logic [IW-1:0] op_idx,
    input  logic [1:0]    op_mode,
    input  logic          op_dbl,
    input  logic          circ_en,
    input  logic [AW-1:0] circ_start,
    input  logic [AW-1:0] circ_end,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [AW-1:0] ld_val,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_val,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] eff_addr_hi,
    output logic [AW-1:0] upd_val,
    output logic          illegal
);

    localparam logic [AW-1:0] HALF_OFS = AW'(WORD_BYTES);

    logic [AW-1:0] cur_val;
    logic [AW-1:0] delta;
    logic [AW-1:0] addr_c;
    logic [AW-1:0] upd_c;
    logic          wr_c;
    logic          bad_c;

    agen_step #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_step (
        .mode  (op_mode),
        .dbl   (op_dbl),
        .delta (delta)
    );

    agen_modify #(.AW(AW), .IW(IW), .SP_IDX(SP_IDX)) u_mod (
        .mode    (op_mode),
        .idx     (op_idx),
        .cur     (cur_val),
        .delta   (delta),
        .circ    (circ_en),
        .start_a (circ_start),
        .end_a   (circ_end),
        .addr    (addr_c),
        .upd     (upd_c),
        .wr      (wr_c),
        .bad     (bad_c)
    );

    agen_bank #(.AW(AW), .NREG(NREG), .IW(IW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (op_en && wr_c),
        .wr_idx (op_idx),
        .wr_val (upd_c),
        .ld_en  (ld_en),
        .ld_idx (ld_idx),
        .ld_val (ld_val),
        .op_idx (op_idx),
        .op_val (cur_val),
        .rd_idx (rd_idx),
        .rd_val (rd_val)
    );

    assign eff_addr    = addr_c;
    assign eff_addr_hi = addr_c + HALF_OFS;
    assign upd_val     = upd_c;
    assign illegal     = bad_c;

endmodule

// File: rtl/mod_addr_gen_chk.sv
module mod_addr_gen_chk #(
    parameter int AW     = 16,
    parameter int IW     = 4,
    parameter int SP_IDX = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_en,
    input logic [IW-1:0] op_idx,
    input logic [1:0]    op_mode,
    input logic          circ_en,
    input logic [AW-1:0] circ_start,
    input logic [AW-1:0] circ_end,
    input logic          ld_en,
    input logic [IW-1:0] ld_idx,
    input logic [IW-1:0] rd_idx,
    input logic [AW-1:0] rd_val,
    input logic [AW-1:0] eff_addr,
    input logic [AW-1:0] eff_addr_hi,
    input logic [AW-1:0] upd_val,
    input logic          illegal
);
    import agen_pkg::*;

    // R3: exact end match in a post mode with circular bit reloads the start
    p_wrap_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_mode == AM_POST_INC || op_mode == AM_POST_DEC) && circ_en && eff_addr == circ_end)
        |-> upd_val == circ_start);

    // R4: pre-decrement on the stack register accesses its new value
    p_predec_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == AM_PRE_DEC && op_idx == IW'(SP_IDX)) |-> (eff_addr == upd_val && !illegal));

    // R5: illegal only for pre-decrement off the stack register, value held
    p_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (op_mode == AM_PRE_DEC && op_idx != IW'(SP_IDX) && upd_val == eff_addr));

    // R6: second half follows the first by one word
    p_hi_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eff_addr_hi == eff_addr + AW'(2));

    // R8: indirect mode neither moves the address nor changes the value
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == AM_HOLD) |-> (upd_val == eff_addr && !illegal));

    // R9: an enabled operation leaves its new value in the register
    p_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !(ld_en && ld_idx == op_idx))
        |=> (rd_idx != $past(op_idx) || rd_val == $past(upd_val)));

endmodule

bind mod_addr_gen mod_addr_gen_chk #(.AW(AW), .IW(IW), .SP_IDX(SP_IDX)) u_chk (.*);

// File: tb/mod_addr_gen_test.sv
module mod_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_en = 1'b0;
    logic [3:0]  op_idx = '0;
    logic [1:0]  op_mode = '0;
    logic        op_dbl = 1'b0;
    logic        circ_en = 1'b0;
    logic [15:0] circ_start = '0;
    logic [15:0] circ_end = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [15:0] ld_val = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_val;
    logic [15:0] eff_addr;
    logic [15:0] eff_addr_hi;
    logic [15:0] upd_val;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mod_addr_gen uut (.*);

    typedef struct packed {
        logic [3:0]  idx;
        logic [15:0] seed;
        logic [1:0]  mode;
        logic        dbl;
        logic        circ;
        logic [15:0] cs;
        logic [15:0] ce;
        logic [15:0] xa;
        logic [15:0] xn;
        logic        xi;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{4'd3,  16'h1000, 2'b01, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h1000, 16'h1002, 1'b0}, // R2 inc word
        '{4'd4,  16'h2000, 2'b10, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h2000, 16'h1FFC, 1'b0}, // R2 dec dbl
        '{4'd5,  16'h0100, 2'b01, 1'b0, 1'b1, 16'h0080, 16'h0100, 16'h0100, 16'h0080, 1'b0}, // R3 wrap
        '{4'd5,  16'h00FE, 2'b01, 1'b0, 1'b1, 16'h0080, 16'h0100, 16'h00FE, 16'h0100, 1'b0}, // R3 short
        '{4'd6,  16'h0100, 2'b10, 1'b1, 1'b1, 16'h0200, 16'h0100, 16'h0100, 16'h0200, 1'b0}, // R3 dec wrap
        '{4'd7,  16'h0100, 2'b01, 1'b0, 1'b0, 16'h0080, 16'h0100, 16'h0100, 16'h0102, 1'b0}, // R3 circ off
        '{4'd15, 16'h8000, 2'b11, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h7FFE, 16'h7FFE, 1'b0}, // R4 word
        '{4'd15, 16'h0040, 2'b11, 1'b1, 1'b1, 16'h0010, 16'h0040, 16'h003C, 16'h003C, 1'b0}, // R4 no wrap
        '{4'd2,  16'h1234, 2'b11, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h1234, 16'h1234, 1'b1}, // R5
        '{4'd1,  16'hFFFE, 2'b01, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'hFFFE, 16'h0002, 1'b0}, // R7 up
        '{4'd0,  16'h0000, 2'b10, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFE, 1'b0}, // R7 down
        '{4'd8,  16'h4444, 2'b00, 1'b1, 1'b1, 16'h0000, 16'h4444, 16'h4444, 16'h4444, 1'b0}  // R8
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic seed_reg(input logic [3:0] i, input logic [15:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = i; ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1 chk("R1 reset", rd_val, 16'h0000);
        end

        for (int k = 0; k < NV; k++) begin
            seed_reg(TBL[k].idx, TBL[k].seed);
            op_idx = TBL[k].idx; op_mode = TBL[k].mode; op_dbl = TBL[k].dbl;
            circ_en = TBL[k].circ; circ_start = TBL[k].cs; circ_end = TBL[k].ce;
            #1;
            chk($sformatf("R2/R3/R4/R5/R7/R8 addr v%0d", k), eff_addr, TBL[k].xa);
            chk($sformatf("R6 hi v%0d", k), eff_addr_hi, TBL[k].xa + 16'd2);
            chk($sformatf("R2/R3/R4/R5/R7/R8 new v%0d", k), upd_val, TBL[k].xn);
            chk($sformatf("R5 flag v%0d", k), {15'd0, illegal}, {15'd0, TBL[k].xi});
            @(negedge clk);
            op_en = 1'b1;
            @(negedge clk);
            op_en = 1'b0;
            rd_idx = TBL[k].idx;
            #1 chk($sformatf("R9 commit v%0d", k), rd_val, TBL[k].xn);
        end

        // R9: enable low leaves the register alone
        seed_reg(4'd9, 16'h3000);
        op_idx = 4'd9; op_mode = 2'b01; op_dbl = 1'b0; circ_en = 1'b0;
        repeat (2) @(negedge clk);
        rd_idx = 4'd9;
        #1 chk("R9 no enable", rd_val, 16'h3000);

        // R10: load wins over a commit to the same register
        @(negedge clk);
        op_en = 1'b1; ld_en = 1'b1; ld_idx = 4'd9; ld_val = 16'hABCD;
        @(negedge clk);
        op_en = 1'b0; ld_en = 1'b0;
        #1 chk("R10 load priority", rd_val, 16'hABCD);

        // R10: load to another register does not block the commit
        @(negedge clk);
        op_en = 1'b1; ld_en = 1'b1; ld_idx = 4'd10; ld_val = 16'h5555;
        @(negedge clk);
        op_en = 1'b0; ld_en = 1'b0;
        #1 chk("R10 commit beside load", rd_val, 16'hABCF);
        rd_idx = 4'd10;
        #1 chk("R10 load value", rd_val, 16'h5555);

        // R5: repeated illegal pre-decrement keeps the register
        seed_reg(4'd11, 16'h0ACE);
        op_idx = 4'd11; op_mode = 2'b11; op_dbl = 1'b1;
        @(negedge clk);
        op_en = 1'b1;
        repeat (2) @(negedge clk);
        op_en = 1'b0;
        rd_idx = 4'd11;
        #1 chk("R5 reg unchanged", rd_val, 16'h0ACE);

        finish_run();
    end

endmodule